// File: doc/BRIEF.md
# Real-Time Clock Register Bank With Coherent Snapshot

This block is the register store that sits behind a three-wire serial front end of a real-time clock. The shifter in front of it turns serial traffic into byte accesses, and the counter logic behind it keeps the running time. The bank keeps a user copy of the seven time and date bytes. It also keeps a control byte that carries a single write-protect bit, a charger configuration byte and 31 bytes of scratch RAM. It decodes the charger configuration into an enable, a diode count and a resistor choice.

Reads of time come from a shadow copy. This copy is captured from the live counters on the clock edge where the transfer enable is first seen high, so a multi-byte read can never see a carry part-way through. Time writes are held in a staging buffer. They are handed to the counters as one commit pulse after the transfer enable drops. A clock burst hands over nothing unless all eight bytes of the burst arrived. RAM bytes are stored as each one arrives.

Address map: in clock space, index 0 to 6 are time bytes, 7 is control and 8 is the charger configuration. Index 9 to 31 has no storage. RAM space has index 0 to 30, and 31 has no storage. In a burst, `accAddr` carries the byte index within the burst.

Top module: `rtcbank`

## Requirements
- R1: On the first clock edge with `ceIn` high after it was low, the seven live time bytes (byte i on `liveTime[8i+7:8i]`) are copied into the shadow. Clock-space reads of index 0 to 6 return the shadow and ignore later changes of `liveTime`. The shadow is 0 after reset.
- R2: A single-byte clock write to index 0 to 6 is staged while `ceIn` is high. One cycle after the clock edge that sees `ceIn` low again, `commitStb` pulses for one cycle. At the same time, `commitMask` bit i marks each written byte, and `commitData` carries those bytes, with 0 in the bytes that were not written. In every other cycle, `commitStb` and `commitMask` are 0.
- R3: A clock burst (`accBurst`=1) commits only if burst indices 0 to 7 were all written in that transfer. It then pulses `commitStb` with mask 7Fh and loads the control byte from burst byte 7. If fewer bytes arrive, nothing is committed.
- R4: The control byte reads back as {wp, 7'b0}, and wp is 1 after reset (read value 80h). A single write to clock index 7 always updates wp from data bit 7, even when wp is 1.
- R5: While wp is 1, single writes to time bytes, writes to the charger byte and all RAM writes are dropped.
- R6: If wp is 1 when a clock burst ends, no byte is committed and the control byte is left unchanged, even when all eight bytes were sent.
- R7: `chgEnable` is 1 only when charger bits 7:4 are 1010, bits 3:2 are 01 or 10, and bits 1:0 are not 00. When enabled, `chgTwoDiodes` equals bit 3 and `chgResSel` equals bits 1:0 (01, 10 and 11 select the low, middle and high resistor). When disabled, both are 0.
- R8: The charger byte resets to 5Ch with the charger disabled. It is reached only by a single access at clock index 8. A burst byte at index 8 or above is ignored.
- R9: RAM writes at index 0 to 30 are stored at once, in both single and burst mode. A burst cut short keeps the bytes that were sent.
- R10: Clock index 9 to 31 and RAM index 31 read 00h, and writes to them are dropped without a commit.
- R11: Accesses with `ceIn` low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceIn | input | 1 | Transfer enable, high for one serial transaction |
| accValid | input | 1 | One-cycle byte access strobe |
| accWrite | input | 1 | 1 = write access |
| accRam | input | 1 | 1 = RAM space, 0 = clock space |
| accBurst | input | 1 | 1 = access belongs to a burst |
| accAddr | input | 5 | Register index or burst byte index, also the read address |
| accWrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data for accRam/accAddr |
| liveTime | input | 56 | Live time bytes from the counters |
| commitStb | output | 1 | One-cycle pulse that hands staged time to the counters |
| commitMask | output | 7 | Bytes to load on commit |
| commitData | output | 56 | Committed time bytes |
| chgEnable | output | 1 | Charger enabled |
| chgTwoDiodes | output | 1 | 1 = two diodes, 0 = one |
| chgResSel | output | 2 | Resistor select code |

## Verification
The hardest case to reach is a clock burst that ends under write protect. Getting there needs wp set first, and the only legal ways to set it are a single control write or a completed burst whose last byte sets it. The stimulus therefore runs a full burst whose control byte is 80h and confirms that wp reads back as 1. It then sends a second complete burst that tries to clear wp, and checks that no commit appears and that control still reads 80h. A burst is also cut short after six bytes, and a ninth burst byte is aimed at the charger index, so that the completion rule and the burst reach are tested separately.

// File: rtl/rtcbank_pkg.sv
package rtcbank_pkg;
  localparam int ADDR_W  = 5;
  localparam int CTL_IDX = 7;
  localparam int TRK_IDX = 8;

  typedef struct packed {
    logic snap;          // capture live time into shadow
    logic stageWr;       // write accWrData into staging slot
    logic ctlWr;         // direct control byte write
    logic ctlFromStage;  // load control from staged burst byte
    logic trkWr;         // charger configuration write
    logic ramWr;         // scratch RAM write
    logic commit;        // hand staged time to counters
  } bankStrb_t;
endpackage

// File: rtl/rtcbank_ctrl.sv
module rtcbank_ctrl
  import rtcbank_pkg::*;
#(
  parameter int TIME_BYTES = 7,
  parameter int RAM_WORDS  = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceIn,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic              accRam,
  input  logic              accBurst,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              wpBit,
  output bankStrb_t         strb,
  output logic [TIME_BYTES:0] stageMask
);
  localparam int NSTG  = TIME_BYTES + 1;
  localparam int IDX_W = $clog2(NSTG);

  logic ceQ, burstQ;
  logic [NSTG-1:0] maskQ, maskBase;
  logic ceRise, ceFall, wrAcc;
  logic [IDX_W-1:0] idx;

  assign idx       = accAddr[IDX_W-1:0];
  assign stageMask = maskQ;

  always_comb begin
    ceRise = ceIn & ~ceQ;
    ceFall = ~ceIn & ceQ;
    wrAcc  = accValid & accWrite & ceIn;
    strb      = '0;
    strb.snap = ceRise;
    if (wrAcc) begin
      if (accRam)
        strb.ramWr = !wpBit && (accAddr < ADDR_W'(RAM_WORDS));
      else if (accBurst)
        strb.stageWr = accAddr < ADDR_W'(NSTG);
      else if (accAddr < ADDR_W'(TIME_BYTES))
        strb.stageWr = !wpBit;
      else if (accAddr == ADDR_W'(CTL_IDX))
        strb.ctlWr = 1'b1;
      else if (accAddr == ADDR_W'(TRK_IDX))
        strb.trkWr = !wpBit;
    end
    if (ceFall) begin
      if (burstQ) begin
        strb.commit       = (&maskQ) && !wpBit;
        strb.ctlFromStage = (&maskQ) && !wpBit;
      end else begin
        strb.commit = |maskQ[TIME_BYTES-1:0];
      end
    end
  end

  always_comb begin
    maskBase = ceRise ? '0 : maskQ;
    if (strb.stageWr) maskBase[idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceQ    <= 1'b0;
      burstQ <= 1'b0;
      maskQ  <= '0;
    end else begin
      ceQ    <= ceIn;
      maskQ  <= maskBase;
      burstQ <= (ceRise ? 1'b0 : burstQ) | (strb.stageWr & accBurst);
    end
  end
endmodule

// File: rtl/rtcbank_dp.sv
module rtcbank_dp
  import rtcbank_pkg::*;
#(
  parameter int         TIME_BYTES = 7,
  parameter int         RAM_WORDS  = 31,
  parameter logic [7:0] TRK_RESET  = 8'h5C,
  parameter logic [7:0] CTL_RESET  = 8'h80
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bankStrb_t                 strb,
  input  logic [TIME_BYTES:0]       stageMask,
  input  logic                      accRam,
  input  logic [ADDR_W-1:0]         accAddr,
  input  logic [7:0]                accWrData,
  input  logic [TIME_BYTES*8-1:0]   liveTime,
  output logic [7:0]                rdData,
  output logic                      wpBit,
  output logic                      commitStb,
  output logic [TIME_BYTES-1:0]     commitMask,
  output logic [TIME_BYTES*8-1:0]   commitData,
  output logic                      chgEnable,
  output logic                      chgTwoDiodes,
  output logic [1:0]                chgResSel
);
  localparam int NSTG  = TIME_BYTES + 1;
  localparam int IDX_W = $clog2(NSTG);

  logic [7:0] shadow [TIME_BYTES];
  logic [7:0] stage  [NSTG];
  logic [7:0] ram    [RAM_WORDS];
  logic [7:0] trkCfg;
  logic [TIME_BYTES*8-1:0] stagedBus;
  logic [IDX_W-1:0] idx;

  assign idx = accAddr[IDX_W-1:0];

  for (genvar i = 0; i < TIME_BYTES; i++) begin : g_byte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shadow[i] <= '0;
      else if (strb.snap) shadow[i] <= liveTime[8*i +: 8];
    end
    assign stagedBus[8*i +: 8] = stageMask[i] ? stage[i] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NSTG; i++) stage[i] <= '0;
      for (int i = 0; i < RAM_WORDS; i++) ram[i] <= '0;
      trkCfg     <= TRK_RESET;
      wpBit      <= CTL_RESET[7];
      commitStb  <= 1'b0;
      commitMask <= '0;
      commitData <= '0;
    end else begin
      if (strb.stageWr) stage[idx] <= accWrData;
      if (strb.ramWr) ram[accAddr] <= accWrData;
      if (strb.trkWr) trkCfg <= accWrData;
      if (strb.ctlWr) wpBit <= accWrData[7];
      else if (strb.ctlFromStage) wpBit <= stage[CTL_IDX][7];
      commitStb  <= strb.commit;
      commitMask <= strb.commit ? stageMask[TIME_BYTES-1:0] : '0;
      commitData <= strb.commit ? stagedBus : '0;
    end
  end

  always_comb begin
    rdData = 8'h00;
    if (accRam) begin
      if (accAddr < ADDR_W'(RAM_WORDS)) rdData = ram[accAddr];
    end else if (accAddr < ADDR_W'(TIME_BYTES)) begin
      rdData = shadow[idx];
    end else if (accAddr == ADDR_W'(CTL_IDX)) begin
      rdData = {wpBit, 7'b0};
    end else if (accAddr == ADDR_W'(TRK_IDX)) begin
      rdData = trkCfg;
    end
  end

  always_comb begin
    chgEnable    = (trkCfg[7:4] == 4'b1010) && (trkCfg[3] ^ trkCfg[2]) && (trkCfg[1:0] != 2'b00);
    chgTwoDiodes = chgEnable & trkCfg[3];
    chgResSel    = chgEnable ? trkCfg[1:0] : 2'b00;
  end
endmodule

// File: rtl/rtcbank.sv
module rtcbank
  import rtcbank_pkg::*;
#(
  parameter int         TIME_BYTES = 7,
  parameter int         RAM_WORDS  = 31,
  parameter logic [7:0] TRK_RESET  = 8'h5C,
  parameter logic [7:0] CTL_RESET  = 8'h80
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ceIn,
  input  logic                    accValid,
  input  logic                    accWrite,
  input  logic                    accRam,
  input  logic                    accBurst,
  input  logic [4:0]              accAddr,
  input  logic [7:0]              accWrData,
  output logic [7:0]              rdData,
  input  logic [TIME_BYTES*8-1:0] liveTime,
  output logic                    commitStb,
  output logic [TIME_BYTES-1:0]   commitMask,
  output logic [TIME_BYTES*8-1:0] commitData,
  output logic                    chgEnable,
  output logic                    chgTwoDiodes,
  output logic [1:0]              chgResSel
);
  bankStrb_t strbBus;
  logic [TIME_BYTES:0] stageMask;
  logic wpBit;

  rtcbank_ctrl #(.TIME_BYTES(TIME_BYTES), .RAM_WORDS(RAM_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceIn(ceIn), .accValid(accValid),
    .accWrite(accWrite), .accRam(accRam), .accBurst(accBurst),
    .accAddr(accAddr), .wpBit(wpBit), .strb(strbBus), .stageMask(stageMask)
  );

  rtcbank_dp #(.TIME_BYTES(TIME_BYTES), .RAM_WORDS(RAM_WORDS),
               .TRK_RESET(TRK_RESET), .CTL_RESET(CTL_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strbBus), .stageMask(stageMask),
    .accRam(accRam), .accAddr(accAddr), .accWrData(accWrData),
    .liveTime(liveTime), .rdData(rdData), .wpBit(wpBit),
    .commitStb(commitStb), .commitMask(commitMask), .commitData(commitData),
    .chgEnable(chgEnable), .chgTwoDiodes(chgTwoDiodes), .chgResSel(chgResSel)
  );
endmodule

// File: rtl/rtcbank_chk.sv
module rtcbank_chk
  import rtcbank_pkg::*;
#(
  parameter int TIME_BYTES = 7
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  ceIn,
  input logic                  accRam,
  input logic [4:0]            accAddr,
  input logic [7:0]            rdData,
  input logic                  commitStb,
  input logic [TIME_BYTES-1:0] commitMask,
  input logic                  chgEnable,
  input logic                  chgTwoDiodes,
  input logic [1:0]            chgResSel,
  input bankStrb_t             strbBus,
  input logic                  wpBit
);
  p_commit_after_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> (!$past(ceIn) && $past(ceIn, 2)));
  p_commit_mask_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> (commitMask != '0));
  p_idle_mask_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    !commitStb |-> (commitMask == '0));
  p_ram_wr_open_r5: assert property (@(posedge clk) disable iff (!rstN)
    strbBus.ramWr |-> !wpBit);
  p_ctl_low_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!accRam && accAddr == 5'd7) |-> (rdData[6:0] == 7'd0));
  p_chg_off_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !chgEnable |-> (chgResSel == 2'b00 && !chgTwoDiodes));
  p_chg_on_res_r7: assert property (@(posedge clk) disable iff (!rstN)
    chgEnable |-> (chgResSel != 2'b00));
  p_ram_top_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    (accRam && accAddr == 5'd31) |-> (rdData == 8'h00));
endmodule

bind rtcbank rtcbank_chk #(.TIME_BYTES(TIME_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .ceIn(ceIn), .accRam(accRam), .accAddr(accAddr),
  .rdData(rdData), .commitStb(commitStb), .commitMask(commitMask),
  .chgEnable(chgEnable), .chgTwoDiodes(chgTwoDiodes), .chgResSel(chgResSel),
  .strbBus(strbBus), .wpBit(wpBit)
);

// File: tb/rtcbank_bench.sv
module rtcbank_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceIn = 1'b0, accValid = 1'b0, accWrite = 1'b0, accRam = 1'b0, accBurst = 1'b0;
  logic [4:0]  accAddr = '0;
  logic [7:0]  accWrData = '0;
  logic [55:0] liveTime = '0;
  logic [7:0]  rdData;
  logic        commitStb, chgEnable, chgTwoDiodes;
  logic [6:0]  commitMask;
  logic [55:0] commitData;
  logic [1:0]  chgResSel;

  int checks = 0, fails = 0;
  bit done = 0;

  localparam int K_RD = 0, K_COMMIT = 1, K_CHG = 2;
  typedef struct { string req; int kind; logic [63:0] exp; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  rtcbank u_rtcbank (
    .clk(clk), .rstN(rstN), .ceIn(ceIn), .accValid(accValid), .accWrite(accWrite),
    .accRam(accRam), .accBurst(accBurst), .accAddr(accAddr), .accWrData(accWrData),
    .rdData(rdData), .liveTime(liveTime), .commitStb(commitStb),
    .commitMask(commitMask), .commitData(commitData), .chgEnable(chgEnable),
    .chgTwoDiodes(chgTwoDiodes), .chgResSel(chgResSel)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [63:0] got;
        it = q.pop_front();
        case (it.kind)
          K_RD:     got = {56'd0, rdData};
          K_COMMIT: got = {commitStb, commitMask, commitData};
          default:  got = {60'd0, chgEnable, chgTwoDiodes, chgResSel};
        endcase
        checks++;
        if (got !== it.exp) begin
          fails++;
          $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
        end
      end
    end
  end

  task automatic expect_item(string r, int k, logic [63:0] e);
    q.push_back('{r, k, e});
    wait (q.size() == 0);
  endtask

  task automatic rd(string r, bit ram, int a, logic [7:0] e);
    accValid = 0; accRam = ram; accAddr = 5'(a);
    expect_item(r, K_RD, {56'd0, e});
  endtask

  task automatic wrByte(bit ram, bit burst, int a, logic [7:0] d);
    @(negedge clk);
    accValid = 1; accWrite = 1; accRam = ram; accBurst = burst;
    accAddr = 5'(a); accWrData = d;
    @(negedge clk);
    accValid = 0; accWrite = 0; accBurst = 0;
  endtask

  task automatic ceUp();
    @(negedge clk); ceIn = 1;
    @(negedge clk);
  endtask

  // drop enable; return just after the edge where a commit would appear
  task automatic ceDown();
    @(negedge clk); ceIn = 0;
    @(posedge clk); #1;
  endtask

  task automatic single(bit ram, int a, logic [7:0] d);
    ceUp(); wrByte(ram, 0, a, d); ceDown();
  endtask

  task automatic noCommit(string r);
    expect_item(r, K_COMMIT, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state
    rd("R4 reset ctl", 0, 7, 8'h80);
    rd("R8 reset trickle", 0, 8, 8'h5C);
    expect_item("R8 reset charger off", K_CHG, 64'd0);
    rd("R1 reset shadow", 0, 0, 8'h00);
    noCommit("R2 no commit at reset");

    // R5: wp=1 after reset blocks ordinary writes
    single(1, 3, 8'hAA);
    rd("R5 ram blocked", 1, 3, 8'h00);
    single(0, 8, 8'hA5);
    rd("R5 trickle blocked", 0, 8, 8'h5C);
    ceUp(); wrByte(0, 0, 4, 8'h33); ceDown();
    noCommit("R5 time write blocked");

    // R4: control always writable, low bits read zero
    single(0, 7, 8'h7F);
    rd("R4 ctl low bits zero", 0, 7, 8'h00);

    // R1: snapshot on enable rise, later live changes invisible
    liveTime = 56'h06050403020100;
    ceUp();
    liveTime = 56'hFFFFFFFFFFFFFF;
    for (int i = 0; i < 7; i++) rd("R1 snapshot byte", 0, i, 8'(i));
    ceDown();
    noCommit("R2 read-only transfer has no commit");

    // R2: single staged write, committed after fall
    ceUp(); wrByte(0, 0, 2, 8'h15);
    noCommit("R2 no commit while enable high");
    ceDown();
    expect_item("R2 single commit", K_COMMIT, {1'b1, 7'h04, 56'h00000000150000});
    noCommit("R2 commit is one pulse");

    // R3: complete burst, control byte sets wp
    ceUp();
    for (int i = 0; i < 7; i++) wrByte(0, 1, i, 8'h10 + 8'(i));
    wrByte(0, 1, 7, 8'h80);
    ceDown();
    expect_item("R3 full burst commit", K_COMMIT, {1'b1, 7'h7F, 56'h16151413121110});
    rd("R3 burst loads ctl", 0, 7, 8'h80);

    // R6: complete burst under wp is fully discarded
    ceUp();
    for (int i = 0; i < 8; i++) wrByte(0, 1, i, 8'h00);
    ceDown();
    noCommit("R6 burst under wp no commit");
    rd("R6 ctl unchanged", 0, 7, 8'h80);

    single(0, 7, 8'h00);
    rd("R4 wp cleared", 0, 7, 8'h00);

    // R3: incomplete burst
    ceUp();
    for (int i = 0; i < 6; i++) wrByte(0, 1, i, 8'h55);
    ceDown();
    noCommit("R3 short burst no commit");

    // R7: charger decode
    single(0, 8, 8'hA5);
    expect_item("R7 one diode low res", K_CHG, 64'h9);
    single(0, 8, 8'hAA);
    expect_item("R7 two diodes mid res", K_CHG, 64'hE);
    single(0, 8, 8'hAF);
    expect_item("R7 diode code 11 off", K_CHG, 64'h0);
    single(0, 8, 8'hA4);
    expect_item("R7 res code 00 off", K_CHG, 64'h0);
    single(0, 8, 8'hB5);
    expect_item("R7 wrong key off", K_CHG, 64'h0);
    single(0, 8, 8'hAB);
    expect_item("R7 two diodes high res", K_CHG, 64'hF);
    rd("R8 trickle readback", 0, 8, 8'hAB);

    // R9: RAM burst stores bytes as they arrive
    ceUp();
    for (int i = 0; i < 3; i++) wrByte(1, 1, i, 8'hC0 + 8'(i));
    ceDown();
    noCommit("R9 ram burst no commit");
    for (int i = 0; i < 3; i++) rd("R9 ram burst byte", 1, i, 8'hC0 + 8'(i));
    rd("R9 unsent ram byte", 1, 3, 8'h00);
    single(1, 30, 8'h3C);
    rd("R9 ram single top", 1, 30, 8'h3C);

    // R10: unimplemented locations
    single(0, 12, 8'h77);
    noCommit("R10 clock gap write no commit");
    rd("R10 clock gap reads zero", 0, 12, 8'h00);
    single(1, 31, 8'h55);
    rd("R10 ram 31 reads zero", 1, 31, 8'h00);

    // R11: access with enable low
    wrByte(1, 0, 5, 8'h99);
    rd("R11 enable low ignored", 1, 5, 8'h00);

    // R8: burst byte at index 8 never reaches charger byte
    ceUp();
    for (int i = 0; i < 8; i++) wrByte(0, 1, i, 8'h01);
    wrByte(0, 1, 8, 8'h00);
    ceDown();
    expect_item("R8 burst commit", K_COMMIT, {1'b1, 7'h7F, 56'h01010101010101});
    rd("R8 trickle not in burst", 0, 8, 8'hAB);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule